// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This controller sits on the host side of a byte-wide parallel flash bus. It accepts one request at a time: a byte program, a sector erase or a whole-chip erase, together with a target address and a data byte. It then drives the device pins through the unlock and command write cycles that the operation needs. Each write is a separate chip-enable window, and the write-enable pulse inside it has a width set in clock cycles.

After the last command write, the controller switches to repeated read cycles and examines the returned status byte. A parameter selects one of two completion methods. In data polling, bit 7 must match the expected value. In toggle polling, bit 6 must stop changing between successive reads. A poll budget limits how long the controller waits. It ends each operation with a one-cycle done pulse or a one-cycle timeout pulse, and then returns to idle.

The controller infers completion only from the bytes it reads back. It does not use any ready or busy pin from the device. All bus timing (address setup, write pulse width, hold and read access) is counted in clock cycles.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the outputs are in their idle state: busy, done and timeout are 0, fl_ce_n, fl_oe_n and fl_we_n are 1, and fl_dq_oe is 0.
- R2: A request with req_op=0 (byte program) produces exactly four writes as (address, data) pairs: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (req_addr, req_data).
- R3: A request with req_op=2 (chip erase) produces exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R4: A request with req_op=1 (sector erase) produces the first five writes of R3, then (req_addr, 30h).
- R5: In every write, fl_we_n is low for exactly WE_LOW_CYC consecutive clocks. During that time fl_ce_n is low, fl_dq_oe is 1, and fl_addr and fl_dq_out stay stable. The device takes the write on the rising edge of fl_we_n.
- R6: With TOGGLE_POLL=0, the operation completes on the first read whose bit 7 equals the expected bit. The expected bit is req_data[7] for a program and 1 for either erase.
- R7: With TOGGLE_POLL=1, reads start right after the last write. The operation completes on the first read whose bit 6 equals bit 6 of the read just before it.
- R8: If MAX_POLLS reads pass without completion, the controller pulses timeout for one cycle, does not pulse done, and returns to idle after exactly MAX_POLLS reads.
- R9: busy rises in the cycle after a request is accepted and stays high until the cycle that carries the one-cycle done or timeout pulse. In that cycle busy is low.
- R10: A request that arrives while busy is high has no effect. A request with req_op=3 is never accepted: busy stays 0 and the bus performs no cycle.
- R11: During a read, fl_oe_n is low, fl_we_n is high and fl_dq_oe is 0. fl_oe_n and fl_we_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 not accepted |
| req_addr | input | AW | Target byte address, or an address inside the sector |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: completion detected |
| timeout | output | 1 | One-cycle pulse: poll budget used up |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | High while the host drives the data bus |
| fl_dq_in | input | 8 | Data read from the flash |

## Verification
Two controllers, one in each polling mode, run the same requests against behavioural flash models. Each model reports status for a chosen number of reads before it returns true data.

Random programs and erases vary the number of busy reads. This shows that data polling depends only on bit 7 against the expected value, and that toggle polling depends only on two equal bit-6 samples in a row. Cases where the last busy read's bit 6 does or does not equal the true bit 6 separate a correct two-read comparison from one that compares against the wrong sample.

Directed cases cover:
- zero busy reads;
- completion on exactly the last allowed read, against a timeout one read later;
- a budget that is never met;
- a second request injected while busy;
- the op code that is not accepted.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  localparam logic [15:0] UNLK_A = 16'h5555;
  localparam logic [15:0] UNLK_B = 16'h2AAA;

  localparam logic [7:0] K_AA   = 8'hAA;
  localparam logic [7:0] K_55   = 8'h55;
  localparam logic [7:0] K_PROG = 8'hA0;
  localparam logic [7:0] K_ERS  = 8'h80;
  localparam logic [7:0] K_CHIP = 8'h10;
  localparam logic [7:0] K_SECT = 8'h30;

  typedef struct packed {
    logic        use_taddr;
    logic        use_tdata;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        last;
  } cmd_t;

  function automatic cmd_t mk_cmd(logic [15:0] a, logic [7:0] d,
                                  logic ta, logic td, logic l);
    cmd_t c;
    c.use_taddr = ta;
    c.use_tdata = td;
    c.addr      = a;
    c.data      = d;
    c.last      = l;
    return c;
  endfunction

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 17
) (
  input  op_e           op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] taddr,
  input  logic [7:0]    tdata,
  output logic [AW-1:0] addr,
  output logic [7:0]    data,
  output logic          last
);

  cmd_t c;

  always_comb begin
    if (op == OP_PROG) begin
      case (step)
        3'd0:    c = mk_cmd(UNLK_A, K_AA, 1'b0, 1'b0, 1'b0);
        3'd1:    c = mk_cmd(UNLK_B, K_55, 1'b0, 1'b0, 1'b0);
        3'd2:    c = mk_cmd(UNLK_A, K_PROG, 1'b0, 1'b0, 1'b0);
        default: c = mk_cmd(16'h0, 8'h00, 1'b1, 1'b1, 1'b1);
      endcase
    end else begin
      case (step)
        3'd0:    c = mk_cmd(UNLK_A, K_AA, 1'b0, 1'b0, 1'b0);
        3'd1:    c = mk_cmd(UNLK_B, K_55, 1'b0, 1'b0, 1'b0);
        3'd2:    c = mk_cmd(UNLK_A, K_ERS, 1'b0, 1'b0, 1'b0);
        3'd3:    c = mk_cmd(UNLK_A, K_AA, 1'b0, 1'b0, 1'b0);
        3'd4:    c = mk_cmd(UNLK_B, K_55, 1'b0, 1'b0, 1'b0);
        default: c = (op == OP_CHIP) ? mk_cmd(UNLK_A, K_CHIP, 1'b0, 1'b0, 1'b1)
                                     : mk_cmd(16'h0, K_SECT, 1'b1, 1'b0, 1'b1);
      endcase
    end
  end

  assign addr = c.use_taddr ? taddr : AW'(c.addr);
  assign data = c.use_tdata ? tdata : c.data;
  assign last = c.last;

endmodule

// File: rtl/flash_bus_phy.sv
module flash_bus_phy #(
  parameter int AW         = 17,
  parameter int SETUP_CYC  = 1,
  parameter int WE_LOW_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int RD_CYC     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  output logic          ready,
  output logic          cyc_done,
  output logic [7:0]    rd_data,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in
);

  localparam int M1   = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int M2   = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  typedef enum logic [2:0] {P_IDLE, P_SETUP, P_LOW, P_HOLD, P_RD} phase_e;

  phase_e        ph;
  logic [CW-1:0] cnt;

  assign ready = (ph == P_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= P_IDLE;
      cnt       <= '0;
      cyc_done  <= 1'b0;
      rd_data   <= 8'h00;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_addr   <= '0;
      fl_dq_out <= 8'h00;
      fl_dq_oe  <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (ph)
        P_IDLE: begin
          if (start) begin
            fl_addr <= addr;
            fl_ce_n <= 1'b0;
            if (is_read) begin
              fl_oe_n <= 1'b0;
              cnt     <= CW'(RD_CYC - 1);
              ph      <= P_RD;
            end else begin
              fl_dq_out <= data;
              fl_dq_oe  <= 1'b1;
              cnt       <= CW'(SETUP_CYC - 1);
              ph        <= P_SETUP;
            end
          end
        end
        P_SETUP: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b0;
            cnt     <= CW'(WE_LOW_CYC - 1);
            ph      <= P_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        P_LOW: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            cnt     <= CW'(HOLD_CYC - 1);
            ph      <= P_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        P_HOLD: begin
          if (cnt == '0) begin
            fl_ce_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            cyc_done <= 1'b1;
            ph       <= P_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        P_RD: begin
          if (cnt == '0) begin
            rd_data  <= fl_dq_in;
            fl_oe_n  <= 1'b1;
            fl_ce_n  <= 1'b1;
            cyc_done <= 1'b1;
            ph       <= P_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= P_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
  parameter int TOGGLE_POLL = 0
) (
  input  logic b7,
  input  logic b6,
  input  logic exp7,
  input  logic prev6,
  input  logic have_prev,
  output logic complete
);

  logic data_ok;
  logic tog_ok;

  assign data_ok  = (b7 == exp7);
  assign tog_ok   = have_prev && (b6 == prev6);
  assign complete = (TOGGLE_POLL != 0) ? tog_ok : data_ok;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW          = 17,
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 3,
  parameter int HOLD_CYC    = 1,
  parameter int RD_CYC      = 2,
  parameter int TOGGLE_POLL = 0,
  parameter int MAX_POLLS   = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in
);

  localparam int PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_POLL} st_e;

  st_e           st;
  op_e           op_q;
  logic [AW-1:0] taddr_q;
  logic [7:0]    tdata_q;
  logic          exp7_q;
  logic [2:0]    step_q;
  logic          pend_q;
  logic [PW-1:0] pcnt_q;
  logic          prev6_q;
  logic          have_prev_q;

  logic          phy_rdy;
  logic          cyc_done;
  logic [7:0]    rd_data;
  logic          start;
  logic          is_read;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          cmd_last;
  logic          complete;
  logic          unused_rd_bits;

  assign unused_rd_bits = ^rd_data[5:0];
  assign start   = (st != S_IDLE) && phy_rdy && !pend_q;
  assign is_read = (st == S_POLL);

  flash_cmd_table #(.AW(AW)) u_tab (
    .op    (op_q),
    .step  (step_q),
    .taddr (taddr_q),
    .tdata (tdata_q),
    .addr  (cmd_addr),
    .data  (cmd_data),
    .last  (cmd_last)
  );

  flash_bus_phy #(
    .AW(AW), .SETUP_CYC(SETUP_CYC), .WE_LOW_CYC(WE_LOW_CYC),
    .HOLD_CYC(HOLD_CYC), .RD_CYC(RD_CYC)
  ) u_phy (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_read   (is_read),
    .addr      (is_read ? taddr_q : cmd_addr),
    .data      (cmd_data),
    .ready     (phy_rdy),
    .cyc_done  (cyc_done),
    .rd_data   (rd_data),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_dq_in  (fl_dq_in)
  );

  flash_poll_eval #(.TOGGLE_POLL(TOGGLE_POLL)) u_eval (
    .b7        (rd_data[7]),
    .b6        (rd_data[6]),
    .exp7      (exp7_q),
    .prev6     (prev6_q),
    .have_prev (have_prev_q),
    .complete  (complete)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      op_q        <= OP_PROG;
      taddr_q     <= '0;
      tdata_q     <= 8'h00;
      exp7_q      <= 1'b1;
      step_q      <= 3'd0;
      pend_q      <= 1'b0;
      pcnt_q      <= '0;
      prev6_q     <= 1'b0;
      have_prev_q <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (start) pend_q <= 1'b1;
      case (st)
        S_IDLE: begin
          if (req_valid && (op_e'(req_op) != OP_NONE)) begin
            op_q    <= op_e'(req_op);
            taddr_q <= req_addr;
            tdata_q <= req_data;
            exp7_q  <= (op_e'(req_op) == OP_PROG) ? req_data[7] : 1'b1;
            step_q  <= 3'd0;
            busy    <= 1'b1;
            st      <= S_WR;
          end
        end
        S_WR: begin
          if (cyc_done) begin
            pend_q <= 1'b0;
            if (cmd_last) begin
              pcnt_q      <= '0;
              have_prev_q <= 1'b0;
              st          <= S_POLL;
            end else begin
              step_q <= step_q + 3'd1;
            end
          end
        end
        S_POLL: begin
          if (cyc_done) begin
            pend_q      <= 1'b0;
            pcnt_q      <= pcnt_q + 1'b1;
            prev6_q     <= rd_data[6];
            have_prev_q <= 1'b1;
            if (complete) begin
              done <= 1'b1;
              busy <= 1'b0;
              st   <= S_IDLE;
            end else if (pcnt_q == PW'(MAX_POLLS - 1)) begin
              timeout <= 1'b1;
              busy    <= 1'b0;
              st      <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW         = 17,
  parameter int WE_LOW_CYC = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dq_out,
  input logic          fl_dq_oe
);

  logic [15:0] wl_cnt;

  always_ff @(posedge clk) begin
    if (rst) wl_cnt <= 16'd0;
    else if (!fl_we_n) wl_cnt <= wl_cnt + 16'd1;
    else wl_cnt <= 16'd0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && !busy && !done && !timeout));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (wl_cnt == 16'(WE_LOW_CYC)));

  // R5
  we_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> (!fl_ce_n && fl_dq_oe));

  // R5
  we_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  // R11
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R9
  finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || timeout) |-> (!busy && $past(busy) && $onehot0({done, timeout})));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .WE_LOW_CYC(WE_LOW_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .fl_ce_n   (fl_ce_n),
  .fl_oe_n   (fl_oe_n),
  .fl_we_n   (fl_we_n),
  .fl_addr   (fl_addr),
  .fl_dq_out (fl_dq_out),
  .fl_dq_oe  (fl_dq_oe)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps

module flash_bfm #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          clr,
  input  int            nbusy,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_out,
  output logic [7:0]    dq_in
);

  logic [AW-1:0] waddr [0:7];
  logic [7:0]    wdata [0:7];
  int            wcnt = 0;
  int            rcnt = 0;
  logic          tog = 1'b0;
  logic          we_d = 1'b1;
  logic          oe_d = 1'b1;
  logic          erase;
  logic [7:0]    lastw;
  logic [7:0]    truev;
  logic          e7;

  initial dq_in = 8'h00;

  assign erase = (wcnt >= 3) && (wdata[2] == 8'h80);
  assign lastw = (wcnt > 0) ? wdata[wcnt-1] : 8'h00;
  assign truev = erase ? 8'hFF : lastw;
  assign e7    = truev[7];

  always @(posedge clk) begin
    we_d <= we_n;
    oe_d <= oe_n;
    if (clr) begin
      wcnt <= 0;
      rcnt <= 0;
      tog  <= 1'b0;
    end else begin
      if (!we_d && we_n && !ce_n && wcnt < 8) begin
        waddr[wcnt] <= addr;
        wdata[wcnt] <= dq_out;
        wcnt        <= wcnt + 1;
      end
      if (oe_d && !oe_n) begin
        rcnt <= rcnt + 1;
        if (rcnt < nbusy) begin
          tog   <= ~tog;
          dq_in <= {~e7, ~tog, 6'h15};
        end else begin
          dq_in <= truev;
        end
      end
    end
  end

endmodule

module flash_cmd_seq_test;

  localparam int AW  = 17;
  localparam int SU  = 2;
  localparam int WL  = 3;
  localparam int HD  = 1;
  localparam int RDC = 2;
  localparam int MP  = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic          clr = 1'b0;
  int            nbusy = 0;

  logic busy_d, done_d, to_d, ce_d, oe_d, we_d, dqoe_d;
  logic busy_t, done_t, to_t, ce_t, oe_t, we_t, dqoe_t;
  logic [AW-1:0] a_d, a_t;
  logic [7:0] do_d, do_t, di_d, di_t;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .SETUP_CYC(SU), .WE_LOW_CYC(WL), .HOLD_CYC(HD),
                  .RD_CYC(RDC), .TOGGLE_POLL(0), .MAX_POLLS(MP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy_d), .done(done_d),
    .timeout(to_d), .fl_ce_n(ce_d), .fl_oe_n(oe_d), .fl_we_n(we_d),
    .fl_addr(a_d), .fl_dq_out(do_d), .fl_dq_oe(dqoe_d), .fl_dq_in(di_d));

  flash_cmd_seq #(.AW(AW), .SETUP_CYC(SU), .WE_LOW_CYC(WL), .HOLD_CYC(HD),
                  .RD_CYC(RDC), .TOGGLE_POLL(1), .MAX_POLLS(MP)) uut_t (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy_t), .done(done_t),
    .timeout(to_t), .fl_ce_n(ce_t), .fl_oe_n(oe_t), .fl_we_n(we_t),
    .fl_addr(a_t), .fl_dq_out(do_t), .fl_dq_oe(dqoe_t), .fl_dq_in(di_t));

  flash_bfm #(.AW(AW)) m_d (.clk(clk), .clr(clr), .nbusy(nbusy), .ce_n(ce_d),
    .oe_n(oe_d), .we_n(we_d), .addr(a_d), .dq_out(do_d), .dq_in(di_d));
  flash_bfm #(.AW(AW)) m_t (.clk(clk), .clr(clr), .nbusy(nbusy), .ce_n(ce_t),
    .oe_n(oe_t), .we_n(we_t), .addr(a_t), .dq_out(do_t), .dq_in(di_t));

  // bus-level monitors for R5 and R11
  int wl_run = 0, wl_pulses = 0, wl_bad = 0, bus_bad = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (!we_d) wl_run <= wl_run + 1;
      else begin
        if (wl_run != 0) begin
          wl_pulses <= wl_pulses + 1;
          if (wl_run != WL) wl_bad <= wl_bad + 1;
        end
        wl_run <= 0;
      end
      if ((!we_d && !oe_d) || (!oe_d && dqoe_d) || (!we_t && !oe_t) || (!oe_t && dqoe_t))
        bus_bad <= bus_bad + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int op);
    return (op == 0) ? 4 : 6;
  endfunction

  function automatic int exp_addr(input int op, input int i, input int a);
    if (op == 0) begin
      if (i == 3) return a;
      return (i == 1) ? 32'h2AAA : 32'h5555;
    end
    if (i == 5) return (op == 2) ? 32'h5555 : a;
    return (i == 1 || i == 4) ? 32'h2AAA : 32'h5555;
  endfunction

  function automatic int exp_data(input int op, input int i, input int d);
    if (op == 0) begin
      case (i)
        0: return 32'hAA;
        1: return 32'h55;
        2: return 32'hA0;
        default: return d;
      endcase
    end
    case (i)
      0, 3: return 32'hAA;
      1, 4: return 32'h55;
      2: return 32'h80;
      default: return (op == 2) ? 32'h10 : 32'h30;
    endcase
  endfunction

  // reads needed to see completion, before the poll budget is applied
  function automatic int need_reads(input bit tgl, input int op, input int d, input int nb);
    bit b;
    if (!tgl) return nb + 1;
    b = (op == 0) ? d[6] : 1'b1;
    if (nb == 0) return 2;
    return ((nb % 2 == 1) == b) ? nb + 1 : nb + 2;
  endfunction

  task automatic run_op(input int op, input int a, input int d, input int nb, input bit poke);
    bit fd, ft, gd_d, gt_d, gd_t, gt_t;
    int guard;
    string wtag;
    @(negedge clk);
    clr = 1'b1;
    nbusy = nb;
    @(negedge clk);
    clr = 1'b0;
    req_valid = 1'b1;
    req_op = op[1:0];
    req_addr = a[AW-1:0];
    req_data = d[7:0];
    @(negedge clk);
    req_valid = 1'b0;
    check(busy_d && busy_t, "R9", {busy_d, busy_t}, 2'b11);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1;
      req_op = (op == 2) ? 2'd0 : 2'd2;
      req_addr = '0;
      req_data = 8'h5A;
      @(negedge clk);
      req_valid = 1'b0;
    end
    fd = 0; ft = 0; gd_d = 0; gt_d = 0; gd_t = 0; gt_t = 0; guard = 0;
    while (!(fd && ft) && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (!fd && (done_d || to_d)) begin
        fd = 1; gd_d = done_d; gt_d = to_d;
        check(!busy_d, "R9", busy_d, 0);
      end
      if (!ft && (done_t || to_t)) begin
        ft = 1; gd_t = done_t; gt_t = to_t;
        check(!busy_t, "R9", busy_t, 0);
      end
    end
    @(negedge clk);
    check(!done_d && !done_t && !to_d && !to_t, "R9", {done_d, done_t, to_d, to_t}, 0);
    wtag = poke ? "R10" : ((op == 0) ? "R2" : ((op == 1) ? "R4" : "R3"));
    for (int w = 0; w < 2; w++) begin
      int wc, rc, nr;
      bit to_exp;
      wc = (w == 0) ? m_d.wcnt : m_t.wcnt;
      rc = (w == 0) ? m_d.rcnt : m_t.rcnt;
      check(wc == exp_len(op), wtag, wc, exp_len(op));
      for (int i = 0; i < exp_len(op) && i < wc; i++) begin
        int wa, wdv;
        wa  = (w == 0) ? int'(m_d.waddr[i]) : int'(m_t.waddr[i]);
        wdv = (w == 0) ? int'(m_d.wdata[i]) : int'(m_t.wdata[i]);
        check(wa == exp_addr(op, i, a[AW-1:0]) && wdv == exp_data(op, i, d[7:0]), wtag,
              (wa << 8) | wdv, (exp_addr(op, i, a[AW-1:0]) << 8) | exp_data(op, i, d[7:0]));
      end
      nr = need_reads(w == 1, op, d[7:0], nb);
      to_exp = nr > MP;
      if (to_exp) begin
        check(rc == MP, "R8", rc, MP);
        check((w == 0 ? gt_d && !gd_d : gt_t && !gd_t), "R8",
              (w == 0 ? {gd_d, gt_d} : {gd_t, gt_t}), 2'b01);
      end else begin
        check(rc == nr, (w == 0) ? "R6" : "R7", rc, nr);
        check((w == 0 ? gd_d && !gt_d : gd_t && !gt_t), (w == 0) ? "R6" : "R7",
              (w == 0 ? {gd_d, gt_d} : {gd_t, gt_t}), 2'b10);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    check(!busy_d && !done_d && !to_d && ce_d && oe_d && we_d && !dqoe_d, "R1",
          {busy_d, done_d, to_d, ce_d, oe_d, we_d, dqoe_d}, 7'b0001110);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_t && !done_t && !to_t && ce_t && oe_t && we_t && !dqoe_t, "R1",
          {busy_t, done_t, to_t, ce_t, oe_t, we_t, dqoe_t}, 7'b0001110);

    // directed cases
    run_op(0, 32'h1F0A5, 32'h80, 0, 0);    // R2 R6 R7: no busy reads
    run_op(0, 32'h00123, 32'h3C, 5, 0);    // R2
    run_op(1, 32'h1A000, 32'h00, 3, 0);    // R4
    run_op(2, 32'h0BEEF, 32'h00, 2, 0);    // R3
    run_op(0, 32'h00040, 32'h40, 3, 0);    // R7: last busy bit6 matches true bit6
    run_op(0, 32'h00041, 32'h00, 3, 0);    // R7: last busy bit6 differs
    run_op(0, 32'h00777, 32'hC0, 19, 0);   // R6 R7: completes on the last allowed read
    run_op(0, 32'h00778, 32'h80, 19, 0);   // R8 for toggle mode, one read past budget
    run_op(2, 32'h00000, 32'h00, 40, 0);   // R8 for both modes
    run_op(1, 32'h05555, 32'h00, 4, 1);    // R10: request while busy
    run_op(0, 32'h12345, 32'h9E, 6, 1);    // R10

    // R10: op code 3 is not accepted
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    req_valid = 1'b1;
    req_op = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    check(!busy_d && !busy_t, "R10", {busy_d, busy_t}, 0);
    repeat (20) @(negedge clk);
    check(m_d.wcnt == 0 && m_d.rcnt == 0 && m_t.wcnt == 0 && m_t.rcnt == 0, "R10",
          m_d.wcnt + m_d.rcnt + m_t.wcnt + m_t.rcnt, 0);

    // random mix
    for (int k = 0; k < 14; k++) begin
      int op, a, d, nb;
      op = int'($urandom % 3);
      a  = int'($urandom & 32'h1FFFF);
      d  = int'($urandom & 32'hFF);
      nb = int'($urandom % 9);
      run_op(op, a, d, nb, 0);
    end

    repeat (4) @(negedge clk);
    check(wl_pulses > 0 && wl_bad == 0, "R5", wl_bad, 0);
    check(bus_bad == 0, "R11", bus_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule